// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the byte-level protocol engine of a two-wire slave memory holding 2048 bytes. A bus front end, outside this block, detects the bus conditions and hands the engine one-cycle strobes: START, STOP, a rising clock edge and a falling clock edge, plus the sampled data line. The engine shifts bytes in and out and decodes the control byte. It answers with a registered "pull data low" output that an open-drain pad would drive.

Writes collect up to one page of bytes in a page buffer. A STOP then starts a timed internal write cycle that copies the buffered bytes into a synchronous RAM. While that cycle runs, the engine acknowledges nothing, so a master can poll for completion. Reads stream bytes from the RAM at an 11-bit address pointer. The pointer is loaded by the word-address phase of a write, and a repeated START hands it to a following read.

Top module: `ee_slave_engine`

## Requirements
- R1: A control byte is sent MSB first as the 4-bit device code 1010, then three block bits, then a direction bit (1 = read, 0 = write). When the code matches and no write cycle is running, the engine pulls data low in the ninth (acknowledge) clock.
- R2: A control byte with any other device code gets no acknowledge, and the engine drives nothing until the next START.
- R3: In a write, the byte after the control byte sets the pointer to {block bits, byte}. Every later byte is data for the address the pointer holds. Address and data bytes are each acknowledged.
- R4: During a write only the low 4 pointer bits advance after each data byte, and the upper 7 bits stay fixed. When more than 16 data bytes arrive, the later bytes overwrite earlier ones in the same page, so the last 16 are kept.
- R5: A STOP after at least one data byte starts an internal write cycle of WR_TICKS clocks. During that cycle no control byte, read or write, is acknowledged.
- R6: With the write-protect input high, data bytes are still acknowledged, but a STOP starts no write cycle, the memory keeps its old contents, and the next control byte is acknowledged at once.
- R7: A read returns the byte at the pointer, MSB first on the data line (pull low = 0). A current-address read after a write returns the byte after the last one written. The block bits of a read control byte do not move the pointer.
- R8: After each read byte the full 11-bit pointer increments. When the master acknowledges, the next byte follows, and the pointer wraps from 0x7FF to 0x000.
- R9: When the master does not acknowledge a read byte, the engine leaves the line released and drives nothing more until the next START.
- R10: A repeated START after the word address keeps the loaded pointer and starts no write cycle, so the following read control byte is acknowledged and reads from that address.
- R11: After reset the engine is idle, the line is released, and no write cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_evt | input | 1 | One-cycle strobe: STOP seen |
| scl_rise | input | 1 | One-cycle strobe: bus clock rose, data line valid |
| scl_fall | input | 1 | One-cycle strobe: bus clock fell, slave may change data |
| sda_in | input | 1 | Sampled level of the data line |
| wp | input | 1 | Write protect, high blocks write cycles |
| sda_pull | output | 1 | Registered: 1 pulls the data line low |

## Verification
The bench fills one page in each of the eight blocks, including the first and last pages, and reads them back. It then reads across the 0x7FF boundary. A pointer that failed to wrap, or that used the block bits wrongly, would return bytes from the wrong block. An 18-byte page write checks the rollover: a pointer that carried into bit 4 would spill into the next page, and a buffer that kept the first bytes would fail the readback. The bench polls immediately after each STOP, expecting at least one missing acknowledge. It also checks write protect by expecting no missing acknowledge and unchanged data, and checks a wrong device code by expecting silence on the line for the whole transaction.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_WADDR,
    S_WDATA,
    S_RD
  } ee_state_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee_mem.sv
module ee_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/ee_pagebuf.sv
module ee_pagebuf #(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 4,
  parameter int WR_TICKS = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     we,
  input  logic [PAGE_W-1:0]        idx,
  input  logic [ADDR_W-PAGE_W-1:0] base_in,
  input  logic [7:0]               wd,
  input  logic                     commit,
  input  logic                     wp,
  output logic                     busy,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [7:0]               mem_wdata
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int TW   = $clog2(WR_TICKS + 1);

  logic [7:0]               data [PAGE];
  logic [PAGE-1:0]          vld;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic [TW-1:0]            tick;
  logic [PAGE_W-1:0]        slot;

  assign slot      = tick[PAGE_W-1:0];
  assign mem_we    = busy && (tick < TW'(PAGE)) && vld[slot];
  assign mem_waddr = {base, slot};
  assign mem_wdata = data[slot];

  always_ff @(posedge clk) begin
    if (we) data[idx] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      base <= '0;
      busy <= 1'b0;
      tick <= '0;
    end else begin
      if (clr) vld <= '0;
      if (we) begin
        vld[idx] <= 1'b1;
        base     <= base_in;
      end
      if (commit && !wp && !busy) begin
        busy <= 1'b1;
        tick <= '0;
      end else if (busy) begin
        if (tick == TW'(WR_TICKS - 1)) begin
          busy <= 1'b0;
          vld  <= '0;
        end
        tick <= tick + 1'b1;
      end
    end
  end

  assert_wp_no_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (commit && wp && !busy) |=> !busy);

  assert_no_fill_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !we);
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
#(
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_evt,
  input  logic                           stop_evt,
  input  logic                           scl_rise,
  input  logic                           scl_fall,
  input  logic                           sda_in,
  input  logic                           busy,
  input  logic [7:0]                     rd_data,
  output logic [BLK_W+7:0]               ptr,
  output logic                           pb_clr,
  output logic                           pb_we,
  output logic [PAGE_W-1:0]              pb_idx,
  output logic [BLK_W+8-PAGE_W-1:0]      pb_base,
  output logic [7:0]                     pb_data,
  output logic                           commit,
  output logic                           sda_pull
);
  localparam int ADDR_W = BLK_W + 8;

  ee_state_t  state;
  logic [3:0] cnt;
  logic       ackph;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic [2:0] blk;
  logic       wseen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ackph    <= 1'b0;
      shreg    <= '0;
      tx       <= '0;
      blk      <= '0;
      wseen    <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      pb_clr   <= 1'b0;
      pb_we    <= 1'b0;
      pb_idx   <= '0;
      pb_base  <= '0;
      pb_data  <= '0;
      commit   <= 1'b0;
    end else begin
      pb_clr <= 1'b0;
      pb_we  <= 1'b0;
      commit <= 1'b0;
      if (start_evt) begin
        state    <= S_CTRL;
        cnt      <= '0;
        ackph    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        if (state == S_WDATA && wseen) commit <= 1'b1;
        state    <= S_IDLE;
        ackph    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (scl_rise) begin
        if (ackph) begin
          ackph <= 1'b0;
          cnt   <= '0;
        end else if (state == S_RD) begin
          if (cnt == 4'd8) begin
            // master acknowledge slot: low continues, high ends the read
            if (sda_in) state <= S_IDLE;
            else        cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == 4'd7) ptr <= ptr + 1'b1;
          end
        end else if (state != S_IDLE && cnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_in};
          cnt   <= cnt + 1'b1;
        end
      end else if (scl_fall) begin
        if (state == S_RD && !ackph) begin
          if (cnt == 4'd0) begin
            sda_pull <= ~rd_data[7];
            tx       <= {rd_data[6:0], 1'b0};
          end else if (cnt < 4'd8) begin
            sda_pull <= ~tx[7];
            tx       <= {tx[6:0], 1'b0};
          end else begin
            sda_pull <= 1'b0;
          end
        end else if (state != S_IDLE && state != S_RD && cnt == 4'd8 && !ackph) begin
          ackph <= 1'b1;
          case (state)
            S_CTRL: begin
              if (shreg[7:4] == DEV_CODE && !busy) begin
                sda_pull <= 1'b1;
                blk      <= shreg[3:1];
                wseen    <= 1'b0;
                state    <= shreg[0] ? S_RD : S_WADDR;
                pb_clr   <= ~shreg[0];
              end else begin
                state <= S_IDLE;
                ackph <= 1'b0;
              end
            end
            S_WADDR: begin
              sda_pull <= 1'b1;
              ptr      <= {blk[BLK_W-1:0], shreg};
              state    <= S_WDATA;
            end
            S_WDATA: begin
              sda_pull           <= 1'b1;
              pb_we              <= 1'b1;
              pb_idx             <= ptr[PAGE_W-1:0];
              pb_base            <= ptr[ADDR_W-1:PAGE_W];
              pb_data            <= shreg;
              ptr[PAGE_W-1:0]    <= ptr[PAGE_W-1:0] + 1'b1;
              wseen              <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          sda_pull <= 1'b0;
        end
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_pull);

  assert_busy_nack_R5: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && !start_evt && !stop_evt && state == S_CTRL && cnt == 4'd8 && !ackph && busy)
      |=> !sda_pull);

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && !start_evt && !stop_evt && !scl_rise && state == S_WDATA && cnt == 4'd8 && !ackph)
      |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  assert_rd_step_R8: assert property (@(posedge clk) disable iff (rst)
    (scl_rise && !start_evt && !stop_evt && state == S_RD && !ackph && cnt == 4'd7)
      |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/ee_slave_engine.sv
module ee_slave_engine #(
  parameter int BLK_W    = 3,
  parameter int PAGE_W   = 4,
  parameter int WR_TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  input  logic wp,
  output logic sda_pull
);
  localparam int ADDR_W = BLK_W + 8;

  logic [ADDR_W-1:0]        ptr;
  logic [7:0]               rd_data;
  logic                     pb_clr, pb_we, commit, busy;
  logic [PAGE_W-1:0]        pb_idx;
  logic [ADDR_W-PAGE_W-1:0] pb_base;
  logic [7:0]               pb_data;
  logic                     mem_we;
  logic [ADDR_W-1:0]        mem_waddr;
  logic [7:0]               mem_wdata;

  ee_ctrl #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .busy(busy), .rd_data(rd_data), .ptr(ptr),
    .pb_clr(pb_clr), .pb_we(pb_we), .pb_idx(pb_idx), .pb_base(pb_base),
    .pb_data(pb_data), .commit(commit), .sda_pull(sda_pull)
  );

  ee_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_TICKS(WR_TICKS)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .we(pb_we), .idx(pb_idx),
    .base_in(pb_base), .wd(pb_data), .commit(commit), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  ee_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!sda_pull && !busy));
endmodule

// File: tb/sim_ee_slave_engine.sv
module sim_ee_slave_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_evt = 1'b0, stop_evt = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic sda_in = 1'b1, wp = 1'b0;
  logic sda_pull;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic seen_pull;
  logic [7:0] exp_mem [2048];

  always #4 clk = ~clk;

  ee_slave_engine u0 (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .wp(wp),
    .sda_pull(sda_pull)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1; @(negedge clk) start_evt = 1'b0; @(negedge clk);
  endtask
  task automatic do_stop();
    @(negedge clk) stop_evt = 1'b1; @(negedge clk) stop_evt = 1'b0; @(negedge clk);
  endtask
  task automatic do_fall();
    @(negedge clk) scl_fall = 1'b1; @(negedge clk) scl_fall = 1'b0; @(negedge clk);
  endtask
  task automatic do_rise();
    @(negedge clk) scl_rise = 1'b1; @(negedge clk) scl_rise = 1'b0; @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      do_fall();
      if (sda_pull) seen_pull = 1'b1;
      sda_in = b[i];
      do_rise();
    end
    do_fall();
    ack = sda_pull;
    sda_in = 1'b1;
    do_rise();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      do_fall();
      b[i] = ~sda_pull;
      do_rise();
    end
    do_fall();
    chk("R8 line released in master ack slot", int'(sda_pull), 0);
    sda_in = mack ? 1'b0 : 1'b1;
    do_rise();
    sda_in = 1'b1;
  endtask

  function automatic logic [7:0] ctl(input int blk, input logic rd);
    return {4'b1010, blk[2:0], rd};
  endfunction

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 29 + seed * 113 + (a >> 3)) & 255);
  endfunction

  task automatic poll(output int nacks);
    logic ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      do_start();
      send_byte(ctl(0, 1'b0), ack);
      do_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  // page write starting at addr, n data bytes
  task automatic wr_page(input int addr, input int n, input int seed);
    logic ack;
    logic [7:0] v;
    do_start();
    send_byte(ctl(addr >> 8, 1'b0), ack);
    chk("R1 write control ack", int'(ack), 1);
    send_byte(8'(addr), ack);
    chk("R3 word address ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      v = pat(addr + k, seed);
      send_byte(v, ack);
      chk("R3 data ack", int'(ack), 1);
      if (!wp) exp_mem[(addr & 'h7F0) | ((addr + k) & 'hF)] = v;
    end
    do_stop();
  endtask

  task automatic rd_seq(input int addr, input int n);
    logic ack;
    logic [7:0] b;
    do_start();
    send_byte(ctl(addr >> 8, 1'b0), ack);
    send_byte(8'(addr), ack);
    do_start();
    send_byte(ctl(7 - (addr >> 8), 1'b1), ack);
    chk("R10 read ack after repeated START", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk("R7/R8 read data", int'(b), int'(exp_mem[(addr + k) & 'h7FF]));
    end
    do_stop();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int n;
    int base;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 line released after reset", int'(sda_pull), 0);

    // R3/R4: fill one page in every block, including first and last pages
    for (int blk = 0; blk < 8; blk++) begin
      base = blk * 256 + ((blk == 7) ? 15 : blk) * 16;
      wr_page(base, 16, blk);
      if (blk == 0) begin
        // R5: read control during the write cycle is not acknowledged
        do_start();
        send_byte(ctl(0, 1'b1), ack);
        chk("R5 no ack while busy", int'(ack), 0);
        do_stop();
      end
      poll(n);
      chk("R5 poll saw busy", int'(n >= 1 || blk == 0), 1);
      chk("R5 poll finished", int'(n < 40), 1);
    end
    for (int blk = 0; blk < 8; blk++)
      rd_seq(blk * 256 + ((blk == 7) ? 15 : blk) * 16, 16);

    // R8: sequential read across the top of the array
    rd_seq('h7F8, 16);

    // R7: current address read continues at 0x008, block bits ignored
    do_start();
    send_byte(ctl(5, 1'b1), ack);
    chk("R7 current read ack", int'(ack), 1);
    recv_byte(1'b0, b);
    chk("R7 current address data", int'(b), int'(exp_mem['h008]));
    // R9: nothing driven after master nack
    do_fall();
    chk("R9 released after nack", int'(sda_pull), 0);
    do_rise();
    do_fall();
    chk("R9 still released", int'(sda_pull), 0);
    do_stop();

    // R4: 18 bytes from offset 14 of page 0x1A0 roll over within the page
    wr_page('h1AE, 18, 9);
    poll(n);
    chk("R4 rollover write cycle ran", int'(n >= 1), 1);
    do_start();
    send_byte(ctl(1, 1'b1), ack);
    recv_byte(1'b0, b);
    chk("R4/R7 current read after rollover", int'(b), int'(exp_mem['h1A0]));
    do_stop();
    chk("R4 last byte kept", int'(exp_mem['h1AF]), int'(pat('h1AE + 17, 9)));
    rd_seq('h1A0, 16);

    // R3: single byte write
    wr_page('h455, 1, 4);
    poll(n);
    chk("R5 byte write cycle ran", int'(n >= 1), 1);
    rd_seq('h455, 1);

    // R2: wrong device code, then silence
    do_start();
    seen_pull = 1'b0;
    send_byte(8'hB0, ack);
    chk("R2 no ack on wrong code", int'(ack), 0);
    send_byte(8'h00, ack);
    chk("R2 no ack on later byte", int'(ack), 0);
    chk("R2 line never driven", int'(seen_pull), 0);
    do_stop();
    rd_seq('h030, 4);

    // R6: write protect
    wp = 1'b1;
    wr_page('h334, 3, 21);
    poll(n);
    chk("R6 no write cycle when protected", n, 0);
    wp = 1'b0;
    rd_seq('h330, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule